// File: doc/BRIEF.md
# Flash Protection and Status Controller

This block guards a byte-wide flash array that is split into eight equal blocks. A client asks for one of three operations on a small command port: program one byte, erase one block, or erase the whole array. A mode input selects between in-system operation and bulk programmer operation. Before any operation starts, the controller checks it against two active-low guard pins and a bank of per-block lock bits. A request that passes starts a timed busy phase. At the end of that phase the array is updated in a single commit cycle. A request that fails is dropped and flagged.

While the controller is busy, a read returns a status byte rather than array data. Bit 7 holds the complement of the bit 7 being written, and bit 6 flips on each read. Once the operation is done, reads return stored data again. The array itself is a small register model whose size is set by parameters.

The state machine has five states:

- **IDLE**: waits for a request.
- **PROGRAM**, **ERASE_BLK**, **ERASE_ALL**: count down the busy time of the accepted operation.
- **COMMIT**: writes the array.

The transitions are:

- IDLE to PROGRAM, ERASE_BLK or ERASE_ALL on an accepted request.
- Each counting state to COMMIT when its counter reaches zero.
- COMMIT to IDLE unconditionally.

A rejected request leaves the machine in IDLE.

Top module: `flash_guard_ctrl`

## Requirements
- R1: After reset every byte reads 0xFF, every lock bit is clear, and `busy` and `cmd_err` are low.
- R2: Operation code 1 (program) stores the old byte ANDed with `cmd_data`. `busy` stays high for PROG_CYC+1 cycles, starting the cycle after the request.
- R3: Operation code 2 (block erase) sets every byte of the block given by `cmd_addr[ADDR_W-1:OFS_W]` to 0xFF and leaves every other block unchanged. `busy` stays high for ERASE_CYC+1 cycles.
- R4: The boot block is the highest block (all block-select bits 1). Program or erase of the boot block is rejected while `boot_guard_n` is low. That pin has no effect on any other block.
- R5: Program or erase of any block other than the boot block is rejected while `array_guard_n` is low. That pin has no effect on the boot block.
- R6: A pulse on `lock_we` writes `lock_set` into the lock bit of block `lock_blk`. A set lock bit rejects program and erase of that block when `prog_mode` is 0 (in-system mode). Lock bits are ignored when `prog_mode` is 1 (programmer mode).
- R7: Operation code 3 (chip erase) is rejected when `prog_mode` is 0, or when either guard pin is low. When accepted, it sets every byte to 0xFF and holds `busy` for ERASE_CYC+1 cycles.
- R8: A rejected request raises `cmd_err` for exactly one cycle, the cycle after the request. It never raises `busy` and leaves the array unchanged.
- R9: A read (`rd_en`) returns its result on `rd_data` one cycle later. During busy that result is a status byte. Bit 7 is the inverse of bit 7 of the target data, where the target is `cmd_data` for a program and 0xFF for an erase. Bit 6 starts at 0 for each operation and inverts on every read. Bits 5:0 are zero.
- R10: Once `busy` is low, a read returns the stored byte, including the result of the operation that just completed.
- R11: A request made while `busy` is high is ignored. It does not raise `cmd_err` and does not change the array. Operation code 0 is never acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_mode | input | 1 | 1 = programmer mode, 0 = in-system mode |
| boot_guard_n | input | 1 | Active-low write guard for the boot block |
| array_guard_n | input | 1 | Active-low write guard for all non-boot blocks |
| lock_we | input | 1 | Lock bit write strobe |
| lock_blk | input | BLK_W | Block whose lock bit is written |
| lock_set | input | 1 | Lock bit value to write |
| cmd_valid | input | 1 | Request strobe |
| cmd_op | input | 2 | 0 none, 1 program, 2 block erase, 3 chip erase |
| cmd_addr | input | BLK_W+OFS_W | Byte address; the top BLK_W bits select the block |
| cmd_data | input | 8 | Program data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | BLK_W+OFS_W | Read address |
| rd_data | output | 8 | Read result, one cycle after `rd_en` |
| busy | output | 1 | An operation is in progress |
| cmd_err | output | 1 | One-cycle reject pulse |

## Verification
Some rules are checked by the assertions on every cycle:

- A chip erase requested in in-system mode is rejected.
- Each guard pin rejects requests to the blocks it covers.
- `cmd_err` only follows a request made while idle, and is never raised together with `busy`.
- Requests made while busy raise no error.
- During busy, the status bits 5:0 stay zero and bit 6 flips between consecutive reads.

Other behaviour can only be shown by the bench's scenarios:

- The stored AND of old and new data after a program.
- The exact extent of an erase.
- Lock bits that act in one mode and not the other.
- The busy lengths.
- The polling value of bit 7.
- The array being left intact after rejected or ignored requests.

// File: rtl/flc_pkg.sv
package flc_pkg;
    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_PROG   = 2'd1,
        OP_BERASE = 2'd2,
        OP_CERASE = 2'd3
    } flc_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PROGRAM,
        S_ERASE_BLK,
        S_ERASE_ALL,
        S_COMMIT
    } flc_state_e;
endpackage

// File: rtl/flc_lock_regs.sv
module flc_lock_regs #(
    parameter int BLK_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [BLK_W-1:0]       blk,
    input  logic                   set_lock,
    output logic [(1<<BLK_W)-1:0]  lock_q
);
    localparam int NBLK = 1 << BLK_W;

    for (genvar b = 0; b < NBLK; b++) begin : g_lock
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lock_q[b] <= 1'b0;
            end else if (we && (blk == BLK_W'(b))) begin
                lock_q[b] <= set_lock;
            end
        end
    end
endmodule

// File: rtl/flc_protect.sv
module flc_protect #(
    parameter int BLK_W = 3
) (
    input  logic                   prog_mode,
    input  logic                   boot_guard_n,
    input  logic                   array_guard_n,
    input  logic [(1<<BLK_W)-1:0]  lock_q,
    input  logic [BLK_W-1:0]       blk,
    output logic                   blk_prot,
    output logic                   any_prot
);
    localparam int NBLK = 1 << BLK_W;

    logic [NBLK-1:0] prot_vec;

    // Lock bits count only in in-system mode.
    for (genvar b = 0; b < NBLK; b++) begin : g_prot
        if (b == NBLK - 1) begin : g_boot
            assign prot_vec[b] = !boot_guard_n || (!prog_mode && lock_q[b]);
        end else begin : g_main
            assign prot_vec[b] = !array_guard_n || (!prog_mode && lock_q[b]);
        end
    end

    assign blk_prot = prot_vec[blk];
    assign any_prot = |prot_vec;
endmodule

// File: rtl/flc_array.sv
module flc_array #(
    parameter int BLK_W = 3,
    parameter int OFS_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    prog_en,
    input  logic                    erase_blk_en,
    input  logic                    erase_all_en,
    input  logic [BLK_W+OFS_W-1:0]  wr_addr,
    input  logic [7:0]              wr_data,
    input  logic [BLK_W+OFS_W-1:0]  rd_addr,
    output logic [7:0]              rd_q
);
    localparam int ADDR_W = BLK_W + OFS_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [7:0]       cells [DEPTH];
    logic [BLK_W-1:0] wr_blk;

    assign wr_blk = wr_addr[ADDR_W-1:OFS_W];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [BLK_W-1:0] MY_BLK = BLK_W'(g >> OFS_W);
        logic [7:0] cell_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= 8'hFF;
            end else if (erase_all_en || (erase_blk_en && wr_blk == MY_BLK)) begin
                cell_q <= 8'hFF;
            end else if (prog_en && wr_addr == ADDR_W'(g)) begin
                // programming can only pull bits low
                cell_q <= cell_q & wr_data;
            end
        end

        assign cells[g] = cell_q;
    end

    assign rd_q = cells[rd_addr];
endmodule

// File: rtl/flc_status.sv
module flc_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       start,
    input  logic       rd_en,
    input  logic       poll_bit,
    input  logic [7:0] arr_q,
    output logic [7:0] rd_data
);
    logic tog_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= 8'h00;
            tog_q   <= 1'b0;
        end else begin
            if (start) begin
                tog_q <= 1'b0;
            end else if (rd_en && busy) begin
                tog_q <= ~tog_q;
            end
            if (rd_en) begin
                rd_data <= busy ? {poll_bit, tog_q, 6'b0} : arr_q;
            end
        end
    end
endmodule

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl
    import flc_pkg::*;
#(
    parameter int BLK_W     = 3,
    parameter int OFS_W     = 4,
    parameter int PROG_CYC  = 10,
    parameter int ERASE_CYC = 200
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    prog_mode,
    input  logic                    boot_guard_n,
    input  logic                    array_guard_n,
    input  logic                    lock_we,
    input  logic [BLK_W-1:0]        lock_blk,
    input  logic                    lock_set,
    input  logic                    cmd_valid,
    input  logic [1:0]              cmd_op,
    input  logic [BLK_W+OFS_W-1:0]  cmd_addr,
    input  logic [7:0]              cmd_data,
    input  logic                    rd_en,
    input  logic [BLK_W+OFS_W-1:0]  rd_addr,
    output logic [7:0]              rd_data,
    output logic                    busy,
    output logic                    cmd_err
);
    localparam int ADDR_W  = BLK_W + OFS_W;
    localparam int NBLK    = 1 << BLK_W;
    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    flc_state_e        state_q, state_d;
    flc_op_e           req_op, lat_op;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] lat_addr;
    logic [7:0]        lat_data;
    logic [NBLK-1:0]   lock_q;
    logic              blk_prot, any_prot;
    logic              req, reject, start;
    logic              prog_en, erase_blk_en, erase_all_en, poll_bit;
    logic [7:0]        arr_q;

    assign req_op = flc_op_e'(cmd_op);

    flc_lock_regs #(.BLK_W(BLK_W)) u_locks (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (lock_we),
        .blk      (lock_blk),
        .set_lock (lock_set),
        .lock_q   (lock_q)
    );

    flc_protect #(.BLK_W(BLK_W)) u_prot (
        .prog_mode     (prog_mode),
        .boot_guard_n  (boot_guard_n),
        .array_guard_n (array_guard_n),
        .lock_q        (lock_q),
        .blk           (cmd_addr[ADDR_W-1:OFS_W]),
        .blk_prot      (blk_prot),
        .any_prot      (any_prot)
    );

    // Request screening: only taken in IDLE.
    always_comb begin
        req    = (state_q == S_IDLE) && cmd_valid && (req_op != OP_NONE);
        reject = 1'b0;
        if (req) begin
            if (req_op == OP_CERASE) begin
                reject = !prog_mode || any_prot;
            end else begin
                reject = blk_prot;
            end
        end
        start = req && !reject;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    unique case (req_op)
                        OP_PROG:   state_d = S_PROGRAM;
                        OP_BERASE: state_d = S_ERASE_BLK;
                        OP_CERASE: state_d = S_ERASE_ALL;
                        default:   state_d = S_IDLE;
                    endcase
                end
            end
            S_PROGRAM, S_ERASE_BLK, S_ERASE_ALL: begin
                if (cnt_q == '0) state_d = S_COMMIT;
            end
            S_COMMIT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register, busy counter and request latches.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            cnt_q    <= '0;
            lat_op   <= OP_NONE;
            lat_addr <= '0;
            lat_data <= 8'h00;
            cmd_err  <= 1'b0;
        end else begin
            state_q <= state_d;
            cmd_err <= reject;
            if (start) begin
                lat_op   <= req_op;
                lat_addr <= cmd_addr;
                lat_data <= cmd_data;
                cnt_q    <= (req_op == OP_PROG) ? CNT_W'(PROG_CYC - 1)
                                                : CNT_W'(ERASE_CYC - 1);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        busy         = (state_q != S_IDLE);
        prog_en      = (state_q == S_COMMIT) && (lat_op == OP_PROG);
        erase_blk_en = (state_q == S_COMMIT) && (lat_op == OP_BERASE);
        erase_all_en = (state_q == S_COMMIT) && (lat_op == OP_CERASE);
        poll_bit     = (lat_op == OP_PROG) ? ~lat_data[7] : 1'b0;
    end

    flc_array #(.BLK_W(BLK_W), .OFS_W(OFS_W)) u_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .prog_en      (prog_en),
        .erase_blk_en (erase_blk_en),
        .erase_all_en (erase_all_en),
        .wr_addr      (lat_addr),
        .wr_data      (lat_data),
        .rd_addr      (rd_addr),
        .rd_q         (arr_q)
    );

    flc_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .start    (start),
        .rd_en    (rd_en),
        .poll_bit (poll_bit),
        .arr_q    (arr_q),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/flc_chk.sv
module flc_chk #(
    parameter int BLK_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prog_mode,
    input logic             boot_guard_n,
    input logic             array_guard_n,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic [BLK_W-1:0] cmd_blk,
    input logic             rd_en,
    input logic [6:0]       rd_stat,
    input logic             busy,
    input logic             cmd_err
);
    localparam logic [BLK_W-1:0] BOOT = {BLK_W{1'b1}};

    // R8
    err_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> !busy);

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> ($past(cmd_valid) && !$past(busy)));

    // R7
    chip_lpc_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && !prog_mode && cmd_op == 2'd3) |=> (cmd_err && !busy));

    // R4
    boot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && !boot_guard_n && (cmd_op == 2'd1 || cmd_op == 2'd2)
         && cmd_blk == BOOT) |=> cmd_err);

    // R5
    array_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && !array_guard_n && (cmd_op == 2'd1 || cmd_op == 2'd2)
         && cmd_blk != BOOT) |=> cmd_err);

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> !cmd_err);

    // R9
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && $past(rd_en && busy)) |=> (rd_stat[6] != $past(rd_stat[6])));

    // R9
    stat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> (rd_stat[5:0] == 6'd0));
endmodule

bind flash_guard_ctrl flc_chk #(.BLK_W(BLK_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .prog_mode     (prog_mode),
    .boot_guard_n  (boot_guard_n),
    .array_guard_n (array_guard_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_blk       (cmd_addr[ADDR_W-1:OFS_W]),
    .rd_en         (rd_en),
    .rd_stat       (rd_data[6:0]),
    .busy          (busy),
    .cmd_err       (cmd_err)
);

// File: tb/sim_flash_guard_ctrl.sv
module sim_flash_guard_ctrl;
    localparam int BLK_W = 3;
    localparam int OFS_W = 4;
    localparam int AW    = BLK_W + OFS_W;
    localparam int PC    = 3;
    localparam int EC    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_mode = 1'b0, boot_guard_n = 1'b1, array_guard_n = 1'b1;
    logic lock_we = 1'b0, lock_set = 1'b0;
    logic [BLK_W-1:0] lock_blk = '0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
    logic [7:0] cmd_data = 8'h00;
    logic rd_en = 1'b0;
    logic [7:0] rd_data;
    logic busy, cmd_err;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    flash_guard_ctrl #(.BLK_W(BLK_W), .OFS_W(OFS_W), .PROG_CYC(PC), .ERASE_CYC(EC)) u0 (
        .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .boot_guard_n(boot_guard_n),
        .array_guard_n(array_guard_n), .lock_we(lock_we), .lock_blk(lock_blk),
        .lock_set(lock_set), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .cmd_err(cmd_err)
    );

    typedef struct packed {
        logic [1:0]    op;
        logic          mode;
        logic          bg;
        logic          ag;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic          xerr;
        logic [AW-1:0] raddr;
        logic [7:0]    xrd;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 1'b1, 1'b1, 7'h05, 8'hA5, 1'b0, 7'h05, 8'hA5},
        '{2'd1, 1'b0, 1'b1, 1'b1, 7'h05, 8'h3C, 1'b0, 7'h05, 8'h24},
        '{2'd1, 1'b0, 1'b1, 1'b0, 7'h12, 8'h0F, 1'b1, 7'h12, 8'hFF},
        '{2'd1, 1'b0, 1'b1, 1'b0, 7'h72, 8'h00, 1'b0, 7'h72, 8'h00},
        '{2'd1, 1'b0, 1'b0, 1'b1, 7'h73, 8'h11, 1'b1, 7'h73, 8'hFF},
        '{2'd1, 1'b0, 1'b0, 1'b1, 7'h14, 8'h55, 1'b0, 7'h14, 8'h55},
        '{2'd2, 1'b0, 1'b0, 1'b1, 7'h70, 8'h00, 1'b1, 7'h72, 8'h00},
        '{2'd2, 1'b0, 1'b1, 1'b1, 7'h70, 8'h00, 1'b0, 7'h72, 8'hFF},
        '{2'd2, 1'b0, 1'b1, 1'b0, 7'h00, 8'h00, 1'b1, 7'h05, 8'h24},
        '{2'd3, 1'b0, 1'b1, 1'b1, 7'h00, 8'h00, 1'b1, 7'h14, 8'h55},
        '{2'd3, 1'b1, 1'b1, 1'b0, 7'h00, 8'h00, 1'b1, 7'h05, 8'h24},
        '{2'd2, 1'b0, 1'b1, 1'b1, 7'h00, 8'h00, 1'b0, 7'h14, 8'h55},
        '{2'd0, 1'b0, 1'b1, 1'b1, 7'h00, 8'h00, 1'b0, 7'h05, 8'hFF},
        '{2'd3, 1'b1, 1'b1, 1'b1, 7'h00, 8'h00, 1'b0, 7'h14, 8'hFF}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                        output logic err);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        err = cmd_err;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                         output logic err, output int cyc);
        send(op, a, d, err);
        wait_idle(cyc);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] q);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        q = rd_data;
    endtask

    task automatic set_lock(input logic [BLK_W-1:0] b, input logic v);
        @(negedge clk);
        lock_we = 1'b1; lock_blk = b; lock_set = v;
        @(negedge clk);
        lock_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic e;
        logic [7:0] q;
        int c;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(cmd_err == 1'b0, "R1 err after reset", cmd_err, 0);
        rd(7'h00, q); check(q == 8'hFF, "R1 byte 0x00", q, 8'hFF);
        rd(7'h7F, q); check(q == 8'hFF, "R1 byte 0x7F", q, 8'hFF);

        // Vector table: R2/R3/R4/R5/R7/R8/R10 scenarios
        for (int i = 0; i < NV; i++) begin
            prog_mode = VECS[i].mode; boot_guard_n = VECS[i].bg; array_guard_n = VECS[i].ag;
            if (VECS[i].op != 2'd0) begin
                issue(VECS[i].op, VECS[i].addr, VECS[i].data, e, c);
                check(e == VECS[i].xerr, $sformatf("R4/R5/R7/R8 vec %0d err", i), e, VECS[i].xerr);
                if (VECS[i].xerr)
                    check(c == 0, $sformatf("R8 vec %0d no busy", i), c, 0);
                else if (VECS[i].op == 2'd1)
                    check(c == PC + 1, $sformatf("R2 vec %0d busy len", i), c, PC + 1);
                else
                    check(c == EC + 1, $sformatf("R3/R7 vec %0d busy len", i), c, EC + 1);
            end
            rd(VECS[i].raddr, q);
            check(q == VECS[i].xrd, $sformatf("R2/R3/R10 vec %0d data", i), q, VECS[i].xrd);
        end

        // R6 lock bits
        prog_mode = 1'b0; boot_guard_n = 1'b1; array_guard_n = 1'b1;
        set_lock(3'd2, 1'b1);
        issue(2'd1, 7'h21, 8'h00, e, c);
        check(e == 1'b1, "R6 locked block in-system", e, 1);
        rd(7'h21, q); check(q == 8'hFF, "R6 locked byte kept", q, 8'hFF);
        prog_mode = 1'b1;
        issue(2'd1, 7'h21, 8'h0F, e, c);
        check(e == 1'b0, "R6 lock ignored in programmer mode", e, 0);
        rd(7'h21, q); check(q == 8'h0F, "R6 programmer write", q, 8'h0F);
        prog_mode = 1'b0;
        set_lock(3'd7, 1'b1);
        issue(2'd2, 7'h70, 8'h00, e, c);
        check(e == 1'b1, "R6 boot lock erase", e, 1);
        set_lock(3'd2, 1'b0);
        issue(2'd1, 7'h22, 8'h33, e, c);
        check(e == 1'b0, "R6 unlocked block", e, 0);
        rd(7'h22, q); check(q == 8'h33, "R6 unlocked write", q, 8'h33);

        // R9 status polling during program with data bit7 = 1
        send(2'd1, 7'h30, 8'h80, e);
        rd(7'h30, q); check(q == 8'h00, "R9 first status", q, 8'h00);
        rd(7'h30, q); check(q == 8'h40, "R9 toggled status", q, 8'h40);
        wait_idle(c);
        rd(7'h30, q); check(q == 8'h80, "R10 data after program", q, 8'h80);
        // R9 program with bit7 = 0
        send(2'd1, 7'h31, 8'h00, e);
        rd(7'h31, q); check(q == 8'h80, "R9 poll bit for zero data", q, 8'h80);
        wait_idle(c);
        // R9 erase polling
        send(2'd2, 7'h40, 8'h00, e);
        rd(7'h40, q); check(q == 8'h00, "R9 erase status", q, 8'h00);
        wait_idle(c);

        // R11 request while busy
        send(2'd1, 7'h50, 8'h00, e);
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_addr = 7'h51; cmd_data = 8'h00;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_err == 1'b0, "R11 no error while busy", cmd_err, 0);
        wait_idle(c);
        rd(7'h51, q); check(q == 8'hFF, "R11 ignored request", q, 8'hFF);
        rd(7'h50, q); check(q == 8'h00, "R11 first op done", q, 8'h00);

        // R1 reset again: array and locks cleared
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(7'h50, q); check(q == 8'hFF, "R1 array after reset", q, 8'hFF);
        issue(2'd1, 7'h7A, 8'h12, e, c);
        check(e == 1'b0, "R1 locks clear after reset", e, 0);

        finish_run();
    end
endmodule